// File: doc/BRIEF.md
# Guest Event Exit Decision Unit

This block sits beside the execution core of a processor that runs a guest operating system in a deprivileged mode. Each cycle it looks at the events the guest raises and decides whether one of them must return control to the monitor. The events arrive as separate lanes: one decoded instruction, one exception, the two interrupt requests and an entry-check failure. When an exit is due, the block emits a registered one-cycle strobe together with a 32-bit reason word and a 32-bit qualification word that describe the winning event.

Some instruction classes always exit. Others exit only when the monitor has set their enable bit in a control word. Exceptions exit when their bit is set in a 32-entry bitmap. Port accesses consult a port bitmap that is stored as two halves, the top bit of the port choosing the half. System-register accesses consult a bitmap per direction, unless bitmap use is switched off, in which case every such access exits. The bitmaps live in the block and the monitor loads them one bit at a time through a configuration write port. The default configuration has 8-bit port numbers and 64 system registers. Instruction decode, emulation and saving guest state are handled elsewhere.

Top module: `vx_exit_unit`

## Requirements
- R1: While reset is asserted and after its release, with no event presented, exit_o is 0 and reason_o and qual_o are 0. Whenever exit_o is 0, reason_o and qual_o are 0.
- R2: An instruction of class 0, 1, 2 or 3 (feature query, secure-mode entry, cache invalidate, hypercall) exits whatever the control words hold. Its reason is 4, 5, 6 or 7 respectively and its qualification is 0.
- R3: Classes 4 (halt), 5 (monitor-wait), 6 (performance-counter read), 7 (timestamp read), 8 (page-table-root load) and 9 (page-table-root store) exit only when pri_ctl bit 0, 1, 2, 3, 4 or 5 respectively is 1. The reasons are 8, 9, 10 and 11 for classes 4 to 7, and 12 for both root classes. For the root classes, qualification bit 0 is 1 for a store and 0 for a load, and the other bits are 0.
- R4: Class 10 (descriptor-table access) exits only when sec_ctl bit 0 is 1, with reason 13. Class 11 (cache write-back) exits only when sec_ctl bit 1 is 1, with reason 14. Classes 14 and 15 never exit.
- R5: An NMI request exits only when pin_ctl bit 1 is 1, with reason 3. An external interrupt request exits only when pin_ctl bit 0 is 1, with reason 2.
- R6: An exception with vector v exits exactly when exc_bitmap bit v is 1. The reason is 1 and the qualification is v.
- R7: A port access (class 12) to port p of size 1 exits when p's bit is set. For p below half the port space, the bit sits at index p of the low half (cfg_sel 0). Otherwise it sits at index p minus half of the high half (cfg_sel 1). The reason is 15.
- R8: A port access of io_size_m1+1 bytes exits if the bit of any port it covers is set. It always exits if it runs past the highest port.
- R9: For a port exit, the qualification holds the port in bits 31:16, io_in in bit 3 and io_size_m1 in bits 2:0, and 0 elsewhere.
- R10: With pri_ctl bit 6 set, a system-register access (class 13) to index i exits when bit i of the read map (cfg_sel 2) or the write map (cfg_sel 3) is set, chosen by sr_write. With pri_ctl bit 6 clear, every access exits. The reason is 16 for a read and 17 for a write. The qualification holds i in bits 15:0 and sr_write in bit 16.
- R11: entry_fail causes an exit with reason 18 in bits 15:0 and bit 31 set, so masking with 0xFFFF leaves 18. Bits 30:16 of reason_o are always 0.
- R12: Among exiting conditions in the same cycle, the order is: entry failure, then unconditional instruction, then exception, then gated instruction (including port and system-register access), then NMI, then external interrupt.
- R13: The outputs reflect the inputs sampled at the previous clock edge and last one cycle. A configuration write affects events presented from the next cycle on, not an event in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_valid | input | 1 | Instruction lane holds an event |
| ev_class | input | 4 | Instruction class code |
| io_port | input | PORT_W | Port number of a port access |
| io_size_m1 | input | 2 | Access size in bytes minus one |
| io_in | input | 1 | 1 for a port read, 0 for a write |
| sr_index | input | SR_W | System-register index |
| sr_write | input | 1 | 1 for a system-register write |
| exc_valid | input | 1 | Exception lane holds an event |
| exc_vector | input | 5 | Exception vector |
| nmi_req | input | 1 | Non-maskable interrupt request |
| ext_irq_req | input | 1 | External interrupt request |
| entry_fail | input | 1 | Guest entry checks failed |
| pin_ctl | input | 2 | Interrupt exit enables |
| pri_ctl | input | 7 | Primary instruction exit enables and bitmap use |
| sec_ctl | input | 2 | Secondary instruction exit enables |
| exc_bitmap | input | 32 | Per-vector exception exit bitmap |
| cfg_we | input | 1 | Bitmap bit write strobe |
| cfg_sel | input | 2 | Map select: 0 low ports, 1 high ports, 2 read, 3 write |
| cfg_addr | input | CFG_AW | Bit index within the selected map |
| cfg_val | input | 1 | Value written |
| exit_o | output | 1 | Exit strobe |
| reason_o | output | 32 | Exit reason word |
| qual_o | output | 32 | Exit qualification word |

## Verification
The hardest case to reach is a multi-byte port access whose bytes fall in different bitmap halves or run off the top of the port space. Reaching it needs the whole port map loaded with known contents through the bit-wide write port. The bench loads both halves with different arithmetic patterns, one bit per cycle. It then sweeps every port with every access size and predicts each outcome from the pattern, so every straddle and every wrap is visited. A same-cycle write and lookup is staged separately to pin down when a new bit becomes visible.

// File: rtl/vx_pkg.sv
package vx_pkg;

    typedef enum logic [3:0] {
        EV_IDENT   = 4'd0,
        EV_SECMODE = 4'd1,
        EV_CINV    = 4'd2,
        EV_HCALL   = 4'd3,
        EV_HALT    = 4'd4,
        EV_MWAIT   = 4'd5,
        EV_PMC     = 4'd6,
        EV_TSC     = 4'd7,
        EV_ROOTLD  = 4'd8,
        EV_ROOTST  = 4'd9,
        EV_DTAB    = 4'd10,
        EV_CWB     = 4'd11,
        EV_PORT    = 4'd12,
        EV_SREG    = 4'd13
    } ev_class_e;

    localparam logic [15:0] RSN_EXC      = 16'd1;
    localparam logic [15:0] RSN_EXTINT   = 16'd2;
    localparam logic [15:0] RSN_NMI      = 16'd3;
    localparam logic [15:0] RSN_IDENT    = 16'd4;
    localparam logic [15:0] RSN_SECMODE  = 16'd5;
    localparam logic [15:0] RSN_CINV     = 16'd6;
    localparam logic [15:0] RSN_HCALL    = 16'd7;
    localparam logic [15:0] RSN_HALT     = 16'd8;
    localparam logic [15:0] RSN_MWAIT    = 16'd9;
    localparam logic [15:0] RSN_PMC      = 16'd10;
    localparam logic [15:0] RSN_TSC      = 16'd11;
    localparam logic [15:0] RSN_ROOT     = 16'd12;
    localparam logic [15:0] RSN_DTAB     = 16'd13;
    localparam logic [15:0] RSN_CWB      = 16'd14;
    localparam logic [15:0] RSN_PORT     = 16'd15;
    localparam logic [15:0] RSN_SREG_RD  = 16'd16;
    localparam logic [15:0] RSN_SREG_WR  = 16'd17;
    localparam logic [15:0] RSN_BADENTRY = 16'd18;

    localparam int FAIL_FLAG_BIT = 31;

    typedef struct packed {
        logic        fire;
        logic [31:0] reason;
        logic [31:0] qual;
    } exit_rec_t;

    function automatic logic is_uncond(input ev_class_e c);
        return (c == EV_IDENT) || (c == EV_SECMODE) ||
               (c == EV_CINV)  || (c == EV_HCALL);
    endfunction

    function automatic logic [15:0] class_reason(input ev_class_e c, input logic wr);
        logic [15:0] r;
        case (c)
            EV_IDENT:   r = RSN_IDENT;
            EV_SECMODE: r = RSN_SECMODE;
            EV_CINV:    r = RSN_CINV;
            EV_HCALL:   r = RSN_HCALL;
            EV_HALT:    r = RSN_HALT;
            EV_MWAIT:   r = RSN_MWAIT;
            EV_PMC:     r = RSN_PMC;
            EV_TSC:     r = RSN_TSC;
            EV_ROOTLD,
            EV_ROOTST:  r = RSN_ROOT;
            EV_DTAB:    r = RSN_DTAB;
            EV_CWB:     r = RSN_CWB;
            EV_PORT:    r = RSN_PORT;
            EV_SREG:    r = wr ? RSN_SREG_WR : RSN_SREG_RD;
            default:    r = 16'd0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/vx_port_map.sv
module vx_port_map #(
    parameter int PORT_W = 8,
    parameter int AW     = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_half,
    input  logic [AW-1:0]     wr_addr,
    input  logic              wr_val,
    input  logic [PORT_W-1:0] port,
    input  logic [1:0]        size_m1,
    output logic              hit
);
    localparam int IDX_W = PORT_W - 1;
    localparam int HALF  = 1 << IDX_W;
    localparam int SPAN  = 4;

    logic [HALF-1:0] half_map [2];
    logic            addr_ok;
    logic [PORT_W:0] pos [SPAN];

    assign addr_ok = ((wr_addr >> IDX_W) == '0);

    for (genvar h = 0; h < 2; h++) begin : g_half
        logic [HALF-1:0] map_d, map_q;

        always_comb begin
            map_d = map_q;
            if (wr_en && (wr_half == h[0]) && addr_ok)
                map_d[wr_addr[IDX_W-1:0]] = wr_val;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) map_q <= '0;
            else        map_q <= map_d;
        end

        assign half_map[h] = map_q;
    end

    for (genvar k = 0; k < SPAN; k++) begin : g_pos
        assign pos[k] = {1'b0, port} + (PORT_W+1)'(k);
    end

    always_comb begin
        hit = 1'b0;
        for (int k = 0; k < SPAN; k++) begin
            if (k <= int'(size_m1)) begin
                if (pos[k][PORT_W])
                    hit = 1'b1;
                else if (half_map[pos[k][IDX_W]][pos[k][IDX_W-1:0]])
                    hit = 1'b1;
            end
        end
    end

endmodule

// File: rtl/vx_sreg_map.sv
module vx_sreg_map #(
    parameter int SR_W = 6,
    parameter int AW   = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic            wr_dir,
    input  logic [AW-1:0]   wr_addr,
    input  logic            wr_val,
    input  logic [SR_W-1:0] index,
    input  logic            is_write,
    output logic            hit
);
    localparam int DEPTH = 1 << SR_W;

    logic [DEPTH-1:0] dir_map [2];
    logic             addr_ok;

    assign addr_ok = ((wr_addr >> SR_W) == '0);

    for (genvar d = 0; d < 2; d++) begin : g_dir
        logic [DEPTH-1:0] map_d, map_q;

        always_comb begin
            map_d = map_q;
            if (wr_en && (wr_dir == d[0]) && addr_ok)
                map_d[wr_addr[SR_W-1:0]] = wr_val;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) map_q <= '0;
            else        map_q <= map_d;
        end

        assign dir_map[d] = map_q;
    end

    assign hit = dir_map[is_write][index];

endmodule

// File: rtl/vx_exit_prio.sv
module vx_exit_prio
    import vx_pkg::*;
#(
    parameter int PORT_W = 8,
    parameter int SR_W   = 6
) (
    input  logic              ev_valid,
    input  ev_class_e         ev_class,
    input  logic [PORT_W-1:0] io_port,
    input  logic [1:0]        io_size_m1,
    input  logic              io_in,
    input  logic              io_hit,
    input  logic [SR_W-1:0]   sr_index,
    input  logic              sr_write,
    input  logic              sr_hit,
    input  logic              exc_valid,
    input  logic [4:0]        exc_vector,
    input  logic [31:0]       exc_bitmap,
    input  logic              nmi_req,
    input  logic              ext_irq_req,
    input  logic              entry_fail,
    input  logic [1:0]        pin_ctl,
    input  logic [6:0]        pri_ctl,
    input  logic [1:0]        sec_ctl,
    output exit_rec_t         dec
);
    logic        uncond_fire;
    logic        gated_fire;
    logic        exc_fire;
    logic [31:0] gated_qual;

    assign uncond_fire = ev_valid && is_uncond(ev_class);
    assign exc_fire    = exc_valid && exc_bitmap[exc_vector];

    always_comb begin
        gated_fire = 1'b0;
        gated_qual = '0;
        case (ev_class)
            EV_HALT:   gated_fire = pri_ctl[0];
            EV_MWAIT:  gated_fire = pri_ctl[1];
            EV_PMC:    gated_fire = pri_ctl[2];
            EV_TSC:    gated_fire = pri_ctl[3];
            EV_ROOTLD: gated_fire = pri_ctl[4];
            EV_ROOTST: begin
                gated_fire    = pri_ctl[5];
                gated_qual[0] = 1'b1;
            end
            EV_DTAB:   gated_fire = sec_ctl[0];
            EV_CWB:    gated_fire = sec_ctl[1];
            EV_PORT: begin
                gated_fire        = io_hit;
                gated_qual[31:16] = 16'(io_port);
                gated_qual[3]     = io_in;
                gated_qual[2:0]   = {1'b0, io_size_m1};
            end
            EV_SREG: begin
                gated_fire        = !pri_ctl[6] || sr_hit;
                gated_qual[15:0]  = 16'(sr_index);
                gated_qual[16]    = sr_write;
            end
            default: gated_fire = 1'b0;
        endcase
        if (!ev_valid) gated_fire = 1'b0;
    end

    always_comb begin
        dec = '0;
        if (entry_fail) begin
            dec.fire                 = 1'b1;
            dec.reason[15:0]         = RSN_BADENTRY;
            dec.reason[FAIL_FLAG_BIT] = 1'b1;
        end else if (uncond_fire) begin
            dec.fire        = 1'b1;
            dec.reason[15:0] = class_reason(ev_class, sr_write);
        end else if (exc_fire) begin
            dec.fire        = 1'b1;
            dec.reason[15:0] = RSN_EXC;
            dec.qual[4:0]   = exc_vector;
        end else if (gated_fire) begin
            dec.fire        = 1'b1;
            dec.reason[15:0] = class_reason(ev_class, sr_write);
            dec.qual        = gated_qual;
        end else if (nmi_req && pin_ctl[1]) begin
            dec.fire        = 1'b1;
            dec.reason[15:0] = RSN_NMI;
        end else if (ext_irq_req && pin_ctl[0]) begin
            dec.fire        = 1'b1;
            dec.reason[15:0] = RSN_EXTINT;
        end
    end

endmodule

// File: rtl/vx_exit_unit.sv
module vx_exit_unit
    import vx_pkg::*;
#(
    parameter int  PORT_W = 8,
    parameter int  SR_W   = 6,
    localparam int CFG_AW = ((PORT_W - 1) > SR_W) ? (PORT_W - 1) : SR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_valid,
    input  logic [3:0]        ev_class,
    input  logic [PORT_W-1:0] io_port,
    input  logic [1:0]        io_size_m1,
    input  logic              io_in,
    input  logic [SR_W-1:0]   sr_index,
    input  logic              sr_write,
    input  logic              exc_valid,
    input  logic [4:0]        exc_vector,
    input  logic              nmi_req,
    input  logic              ext_irq_req,
    input  logic              entry_fail,
    input  logic [1:0]        pin_ctl,
    input  logic [6:0]        pri_ctl,
    input  logic [1:0]        sec_ctl,
    input  logic [31:0]       exc_bitmap,
    input  logic              cfg_we,
    input  logic [1:0]        cfg_sel,
    input  logic [CFG_AW-1:0] cfg_addr,
    input  logic              cfg_val,
    output logic              exit_o,
    output logic [31:0]       reason_o,
    output logic [31:0]       qual_o
);
    logic      io_hit;
    logic      sr_hit;
    exit_rec_t dec;
    exit_rec_t out_d, out_q;

    vx_port_map #(.PORT_W(PORT_W), .AW(CFG_AW)) u_port_map (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_we && !cfg_sel[1]),
        .wr_half (cfg_sel[0]),
        .wr_addr (cfg_addr),
        .wr_val  (cfg_val),
        .port    (io_port),
        .size_m1 (io_size_m1),
        .hit     (io_hit)
    );

    vx_sreg_map #(.SR_W(SR_W), .AW(CFG_AW)) u_sreg_map (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_we && cfg_sel[1]),
        .wr_dir   (cfg_sel[0]),
        .wr_addr  (cfg_addr),
        .wr_val   (cfg_val),
        .index    (sr_index),
        .is_write (sr_write),
        .hit      (sr_hit)
    );

    vx_exit_prio #(.PORT_W(PORT_W), .SR_W(SR_W)) u_prio (
        .ev_valid    (ev_valid),
        .ev_class    (ev_class_e'(ev_class)),
        .io_port     (io_port),
        .io_size_m1  (io_size_m1),
        .io_in       (io_in),
        .io_hit      (io_hit),
        .sr_index    (sr_index),
        .sr_write    (sr_write),
        .sr_hit      (sr_hit),
        .exc_valid   (exc_valid),
        .exc_vector  (exc_vector),
        .exc_bitmap  (exc_bitmap),
        .nmi_req     (nmi_req),
        .ext_irq_req (ext_irq_req),
        .entry_fail  (entry_fail),
        .pin_ctl     (pin_ctl),
        .pri_ctl     (pri_ctl),
        .sec_ctl     (sec_ctl),
        .dec         (dec)
    );

    always_comb begin
        out_d = dec;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign exit_o   = out_q.fire;
    assign reason_o = out_q.reason;
    assign qual_o   = out_q.qual;

    // R1: no exit means quiet reason and qualification words
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !exit_o |-> (reason_o == 32'd0 && qual_o == 32'd0));

    // R11: the gap between the basic reason and the failure flag stays clear
    p_reason_gap_r11: assert property (@(posedge clk) disable iff (!rst_n)
        reason_o[30:16] == 15'd0);

    // R11: a failed entry check always surfaces with the flag set
    p_entry_fail_r11: assert property (@(posedge clk) disable iff (!rst_n)
        entry_fail |=> (exit_o && reason_o[FAIL_FLAG_BIT]));

    // R2: unconditional classes exit one cycle later without the flag
    p_uncond_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_valid && ev_class < 4'd4 && !entry_fail)
        |=> (exit_o && !reason_o[FAIL_FLAG_BIT]));

    // R5: a masked NMI alone produces no exit
    p_nmi_masked_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (nmi_req && !pin_ctl[1] && !ev_valid && !exc_valid && !ext_irq_req && !entry_fail)
        |=> !exit_o);

    // R6: an exception with its bitmap bit set exits unless outranked
    p_exc_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_valid && exc_bitmap[exc_vector] && !entry_fail &&
         !(ev_valid && ev_class < 4'd4))
        |=> (exit_o && reason_o == 32'd1));

endmodule

// File: tb/sim_vx_exit_unit.sv
module sim_vx_exit_unit;
    localparam int PW   = 8;
    localparam int SW   = 6;
    localparam int AW   = 7;
    localparam int NP   = 1 << PW;
    localparam int HALF = NP / 2;
    localparam int NS   = 1 << SW;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst_n;
    logic          ev_valid;
    logic [3:0]    ev_class;
    logic [PW-1:0] io_port;
    logic [1:0]    io_size_m1;
    logic          io_in;
    logic [SW-1:0] sr_index;
    logic          sr_write;
    logic          exc_valid;
    logic [4:0]    exc_vector;
    logic          nmi_req;
    logic          ext_irq_req;
    logic          entry_fail;
    logic [1:0]    pin_ctl;
    logic [6:0]    pri_ctl;
    logic [1:0]    sec_ctl;
    logic [31:0]   exc_bitmap;
    logic          cfg_we;
    logic [1:0]    cfg_sel;
    logic [AW-1:0] cfg_addr;
    logic          cfg_val;
    logic          exit_o;
    logic [31:0]   reason_o;
    logic [31:0]   qual_o;

    vx_exit_unit #(.PORT_W(PW), .SR_W(SW)) u0 (
        .clk(clk), .rst_n(rst_n), .ev_valid(ev_valid), .ev_class(ev_class),
        .io_port(io_port), .io_size_m1(io_size_m1), .io_in(io_in),
        .sr_index(sr_index), .sr_write(sr_write), .exc_valid(exc_valid),
        .exc_vector(exc_vector), .nmi_req(nmi_req), .ext_irq_req(ext_irq_req),
        .entry_fail(entry_fail), .pin_ctl(pin_ctl), .pri_ctl(pri_ctl),
        .sec_ctl(sec_ctl), .exc_bitmap(exc_bitmap), .cfg_we(cfg_we),
        .cfg_sel(cfg_sel), .cfg_addr(cfg_addr), .cfg_val(cfg_val),
        .exit_o(exit_o), .reason_o(reason_o), .qual_o(qual_o)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clear_in();
        ev_valid = 0; ev_class = 0; io_port = 0; io_size_m1 = 0; io_in = 0;
        sr_index = 0; sr_write = 0; exc_valid = 0; exc_vector = 0;
        nmi_req = 0; ext_irq_req = 0; entry_fail = 0; cfg_we = 0;
    endtask

    task automatic cfg_write(input logic [1:0] sel, input int addr, input bit val);
        cfg_we = 1'b1; cfg_sel = sel; cfg_addr = AW'(addr); cfg_val = val;
        tick();
        cfg_we = 1'b0;
    endtask

    task automatic expect_out(input bit e, input logic [31:0] r,
                              input logic [31:0] q, input string tag);
        chk(exit_o == e, tag, 32'(exit_o), 32'(e));
        chk(reason_o == (e ? r : 32'd0), tag, reason_o, e ? r : 32'd0);
        chk(qual_o == (e ? q : 32'd0), tag, qual_o, e ? q : 32'd0);
    endtask

    function automatic bit port_bit(input int q);
        if (q < HALF) return (q % 5) == 0;
        return ((q - HALF) % 3) == 0;
    endfunction

    function automatic bit port_exit(input int p, input int s);
        for (int k = 0; k <= s; k++) begin
            if (p + k >= NP) return 1'b1;
            if (port_bit(p + k)) return 1'b1;
        end
        return 1'b0;
    endfunction

    function automatic bit rd_bit(input int i); return (i % 4) == 1; endfunction
    function automatic bit wr_bit(input int i); return (i % 3) == 2; endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog R13 actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        clear_in();
        pin_ctl = 0; pri_ctl = 0; sec_ctl = 0; exc_bitmap = 0;
        cfg_sel = 0; cfg_addr = 0; cfg_val = 0;
        repeat (3) @(negedge clk);
        expect_out(1'b0, 0, 0, "R1 in reset");
        rst_n = 1'b1;
        tick();
        expect_out(1'b0, 0, 0, "R1 after reset");

        // R2: unconditional classes under empty and full controls
        for (int c = 0; c < 4; c++) begin
            for (int m = 0; m < 2; m++) begin
                pri_ctl = m ? 7'h7F : 7'h00;
                sec_ctl = m ? 2'h3 : 2'h0;
                pin_ctl = m ? 2'h3 : 2'h0;
                ev_valid = 1; ev_class = 4'(c);
                tick();
                expect_out(1'b1, 32'(4 + c), 0, "R2");
                clear_in();
            end
        end
        pin_ctl = 0; sec_ctl = 0;

        // R3: primary-gated classes, own bit alone and all but own bit
        for (int c = 4; c < 10; c++) begin
            int b;
            logic [31:0] er;
            b  = c - 4;
            er = (c < 8) ? 32'(c + 4) : 32'd12;
            for (int m = 0; m < 3; m++) begin
                bit e;
                case (m)
                    0: begin pri_ctl = 7'h00; e = 0; end
                    1: begin pri_ctl = 7'(1 << b); e = 1; end
                    default: begin pri_ctl = 7'h7F & ~7'(1 << b); e = 0; end
                endcase
                ev_valid = 1; ev_class = 4'(c);
                tick();
                expect_out(e, er, (c == 9) ? 32'd1 : 32'd0, "R3");
                clear_in();
            end
        end
        pri_ctl = 0;

        // R4: secondary-gated classes and reserved classes
        for (int c = 10; c < 12; c++) begin
            for (int m = 0; m < 4; m++) begin
                sec_ctl = 2'(m);
                ev_valid = 1; ev_class = 4'(c);
                tick();
                expect_out(((m >> (c - 10)) & 1) == 1, 32'(c + 3), 0, "R4");
                clear_in();
            end
        end
        for (int c = 14; c < 16; c++) begin
            sec_ctl = 2'h3; pri_ctl = 7'h7F; pin_ctl = 2'h0;
            ev_valid = 1; ev_class = 4'(c);
            tick();
            expect_out(1'b0, 0, 0, "R4 reserved");
            clear_in();
        end
        sec_ctl = 0; pri_ctl = 0;

        // R5: interrupt gating
        for (int m = 0; m < 4; m++) begin
            pin_ctl = 2'(m);
            nmi_req = 1;
            tick();
            expect_out(m[1], 32'd3, 0, "R5 nmi");
            clear_in();
            ext_irq_req = 1;
            tick();
            expect_out(m[0], 32'd2, 0, "R5 ext");
            clear_in();
        end
        pin_ctl = 0;

        // R6: exception bitmap, every vector
        exc_bitmap = 32'h9D2C_5B61;
        for (int v = 0; v < 32; v++) begin
            exc_valid = 1; exc_vector = 5'(v);
            tick();
            expect_out(exc_bitmap[v], 32'd1, 32'(v), "R6");
            clear_in();
        end
        exc_bitmap = 32'h0000_0040;
        exc_valid = 1; exc_vector = 5'd6;
        tick();
        expect_out(1'b1, 32'd1, 32'd6, "R6 vector 6");
        clear_in();
        exc_valid = 1; exc_vector = 5'd5;
        tick();
        expect_out(1'b0, 0, 0, "R6 vector 5");
        clear_in();
        exc_bitmap = 0;

        // R7 R8 R9: load both port halves, sweep every port and size
        for (int i = 0; i < HALF; i++) cfg_write(2'd0, i, port_bit(i));
        for (int i = 0; i < HALF; i++) cfg_write(2'd1, i, port_bit(i + HALF));
        for (int p = 0; p < NP; p++) begin
            for (int s = 0; s < 4; s++) begin
                bit e;
                logic [31:0] eq;
                e  = port_exit(p, s);
                eq = (32'(p) << 16) | (32'(p & 1) << 3) | 32'(s);
                ev_valid = 1; ev_class = 4'd12;
                io_port = PW'(p); io_size_m1 = 2'(s); io_in = p[0];
                tick();
                chk(exit_o == e, (s == 0) ? "R7" : "R8", 32'(exit_o), 32'(e));
                if (e) begin
                    chk(reason_o == 32'd15, "R7", reason_o, 32'd15);
                    chk(qual_o == eq, "R9", qual_o, eq);
                end
                clear_in();
            end
        end

        // R10: system-register bitmaps in use
        for (int i = 0; i < NS; i++) cfg_write(2'd2, i, rd_bit(i));
        for (int i = 0; i < NS; i++) cfg_write(2'd3, i, wr_bit(i));
        for (int m = 0; m < 2; m++) begin
            pri_ctl = m ? 7'h00 : 7'h40;
            for (int i = 0; i < NS; i++) begin
                for (int w = 0; w < 2; w++) begin
                    bit e;
                    e = (m == 1) ? 1'b1 : (w ? wr_bit(i) : rd_bit(i));
                    ev_valid = 1; ev_class = 4'd13;
                    sr_index = SW'(i); sr_write = w[0];
                    tick();
                    expect_out(e, w ? 32'd17 : 32'd16,
                               32'(i) | (32'(w) << 16), "R10");
                    clear_in();
                end
            end
        end
        pri_ctl = 0;

        // R11: entry failure, reason flag and mask
        entry_fail = 1; ev_valid = 1; ev_class = 4'd0; nmi_req = 1; pin_ctl = 2'h3;
        tick();
        expect_out(1'b1, 32'h8000_0012, 0, "R11");
        chk((reason_o & 32'hFFFF) == 32'd18, "R11 mask", reason_o & 32'hFFFF, 32'd18);
        clear_in();
        pin_ctl = 0;

        // R12: priority between lanes
        exc_bitmap = 32'hFFFF_FFFF; pin_ctl = 2'h3; pri_ctl = 7'h01;
        ev_valid = 1; ev_class = 4'd3; exc_valid = 1; exc_vector = 5'd9; nmi_req = 1;
        tick();
        expect_out(1'b1, 32'd7, 0, "R12 uncond over exception");
        clear_in();
        ev_valid = 1; ev_class = 4'd12; io_port = 0; exc_valid = 1; exc_vector = 5'd2;
        tick();
        expect_out(1'b1, 32'd1, 32'd2, "R12 exception over port");
        clear_in();
        ev_valid = 1; ev_class = 4'd12; io_port = 0; nmi_req = 1;
        tick();
        expect_out(1'b1, 32'd15, 32'd0, "R12 port over nmi");
        clear_in();
        pri_ctl = 7'h00;
        ev_valid = 1; ev_class = 4'd4; nmi_req = 1; ext_irq_req = 1;
        tick();
        expect_out(1'b1, 32'd3, 0, "R12 nmi over ext");
        clear_in();
        exc_bitmap = 32'h0; pri_ctl = 7'h01;
        ev_valid = 1; ev_class = 4'd4; exc_valid = 1; exc_vector = 5'd1; ext_irq_req = 1;
        tick();
        expect_out(1'b1, 32'd8, 0, "R12 gated over ext");
        clear_in();
        pin_ctl = 0; pri_ctl = 0;

        // R13: one-cycle pulse and write visibility
        tick();
        expect_out(1'b0, 0, 0, "R13 pulse ends");
        cfg_we = 1; cfg_sel = 2'd0; cfg_addr = AW'(2); cfg_val = 1'b1;
        ev_valid = 1; ev_class = 4'd12; io_port = PW'(2); io_size_m1 = 0;
        tick();
        expect_out(1'b0, 0, 0, "R13 same-cycle write");
        clear_in();
        ev_valid = 1; ev_class = 4'd12; io_port = PW'(2); io_size_m1 = 0;
        tick();
        expect_out(1'b1, 32'd15, 32'h0002_0000, "R13 next-cycle write");
        clear_in();

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule